// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Encoder

This block turns a stream of stereo or mono audio samples into a single biphase-mark coded serial line for a consumer or professional digital audio link. For every frame it requests one sample pair (stereo) or one sample per subframe (mono). It captures the audio words together with the per-subframe validity, user and channel-status flags, builds two 32-slot subframes, and drives the coded line with one half-cell per clock. The clock therefore runs at 128 times the output frame rate.

Each subframe opens with a synchronisation preamble. The preamble that starts a 192-frame channel-status block differs from the other subframe-A preambles, and subframe B has its own. The encoder counts block position itself. Channel-status bits can come separately from the A and B inputs, or one input can feed both subframes. When the first channel-status bit of a block marks professional use, the encoder replaces the last eight channel-status bits of the block with a CRC that it computes over the preceding 184 bits. In mono mode, successive samples of one chosen input channel fill subframes A and B, so the frame rate is half the sample rate. A mute input zeroes the audio of the samples it is captured with.

Top module: `aes_frame_encoder`

## Requirements
- R1: While `rst_n` is low, `tx` is 0. After release, `tx` stays 0 for two more cycles. The first cycle after release carries a sample request.
- R2: Each slot lasts two clock cycles and a subframe lasts 64 cycles. `smp_req` is high for exactly one cycle: every 128 cycles in stereo mode, every 64 cycles in mono mode. Inputs are captured at the clock edge that ends the request cycle. The first half-cell of the next subframe appears on `tx` two cycles after the request cycle.
- R3: The subframe slots run in this order: 4 preamble slots, 24 audio bits LSB first (audio bit i in slot 4+i), then validity (slot 28), user (slot 29), channel status (slot 30) and parity (slot 31).
- R4: The parity slot makes slots 4 to 31 hold an even number of ones, so the line returns to its pre-preamble level at the end of every subframe.
- R5: The preamble half-cell patterns are 11101000 for the block-start A subframe (frame 0 of each 192-frame block), 11100010 for every other A subframe, and 11100100 for B subframes. They are sent first bit leftmost, and each bit is XORed with the line level before the preamble.
- R6: The line toggles at the start of every data slot, and toggles again mid-slot only when the slot bit is 1.
- R7: In stereo mode, subframe A carries `aud_left` with `vflag_a`/`ubit_a`, and subframe B carries `aud_right` with `vflag_b`/`ubit_b`.
- R8: In mono mode, each request captures one sample from `aud_right` when `mono_right`=1, or from `aud_left` when it is 0. The A-request sample goes to subframe A and the B-request sample goes to subframe B. The V, U and C flags of both subframes are captured at the A request.
- R9: With `cs_shared`=0, subframe A sends `cbit_a` and subframe B sends `cbit_b`. With `cs_shared`=1, both send `cbit_b` when `cs_right_sel`=1, or `cbit_a` when it is 0.
- R10: When a subframe's channel-status bit in frame 0 is 1, frames 184+k (k=0..7) send bit k of an 8-bit CRC register in that subframe. The register is preset to 0xFF. For each channel-status bit b of frames 0..183 in order, it is shifted left and XORed with 0x1D whenever (old bit 7 XOR b) is 1. When the frame-0 bit is 0, the input bits pass through.
- R11: When `mute` is 1 at a capture, the audio slots of the subframes fed by that capture are all zero. Validity, user, channel-status and parity are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (128 x frame rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mono_en | input | 1 | 1 selects mono mode |
| mono_right | input | 1 | Mono channel choice, sampled per request |
| cs_shared | input | 1 | One channel-status source for both subframes |
| cs_right_sel | input | 1 | Shared source is the B input when 1 |
| mute | input | 1 | Zero the audio of the captured sample(s) |
| aud_left | input | AUD_W | Left / A audio word |
| aud_right | input | AUD_W | Right / B audio word |
| vflag_a | input | 1 | Validity flag, subframe A |
| vflag_b | input | 1 | Validity flag, subframe B |
| ubit_a | input | 1 | User bit, subframe A |
| ubit_b | input | 1 | User bit, subframe B |
| cbit_a | input | 1 | Channel-status bit, A input |
| cbit_b | input | 1 | Channel-status bit, B input |
| smp_req | output | 1 | Inputs are captured at the end of this cycle |
| tx | output | 1 | Biphase-mark coded line |

## Verification
A wrong slot or frame count shows up as a misplaced preamble within one subframe: a block-start pattern appears in the wrong frame, or the request spacing drifts. A wrong parity or coder state breaks the return of the line to its pre-preamble level, and this is visible at the next preamble, at most 64 cycles later. A fault in CRC accumulation stays hidden until frames 184 to 191 of a professional block, so each run lasts past one full 192-frame block per mode.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  // subframe synchronisation patterns, half-cell 0 in bit 7
  typedef enum logic [1:0] {
    PRE_X = 2'd0,
    PRE_Y = 2'd1,
    PRE_Z = 2'd2
  } pre_kind_e;

  localparam int          PRE_SLOTS  = 4;
  localparam int          TAIL_SLOTS = 4;
  localparam logic [7:0]  CRC_PRESET = 8'hFF;
  localparam logic [7:0]  CRC_POLY   = 8'h1D;

  function automatic logic [7:0] pre_cells(pre_kind_e k);
    case (k)
      PRE_Z:   return 8'b1110_1000;
      PRE_Y:   return 8'b1110_0100;
      default: return 8'b1110_0010;
    endcase
  endfunction

  // one serial step of the channel-status CRC
  function automatic logic [7:0] crc_step(logic [7:0] r, logic b);
    logic fb;
    fb = r[7] ^ b;
    return {r[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

  // even parity across the audio word and three flags
  function automatic logic even_par(logic [31:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/aes_slot_timer.sv
module aes_slot_timer #(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 192
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic                      half,
  output logic [$clog2(SLOTS)-1:0]  slot,
  output logic                      sub_b,
  output logic [$clog2(FRAMES)-1:0] frame,
  output logic [$clog2(FRAMES)-1:0] frame_nxt,
  output logic                      sf_end
);
  localparam int SW = $clog2(SLOTS);
  localparam int FW = $clog2(FRAMES);
  localparam logic [SW-1:0] LAST_SLOT  = SW'(SLOTS - 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

  assign frame_nxt = (frame == LAST_FRAME) ? '0 : frame + 1'b1;
  assign sf_end    = half && (slot == LAST_SLOT);

  // reset parks the counters on the last half-cell of a B subframe of the
  // last frame, so the first cycle after release is a capture cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b1;
      slot  <= LAST_SLOT;
      sub_b <= 1'b1;
      frame <= LAST_FRAME;
    end else begin
      half <= ~half;
      if (half) begin
        if (slot == LAST_SLOT) begin
          slot  <= '0;
          sub_b <= ~sub_b;
          if (sub_b) frame <= frame_nxt;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  p_frame_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame) < FRAMES);

  p_sfend_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> !sf_end);

  p_sub_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sf_end |=> (sub_b != $past(sub_b)));

endmodule

// File: rtl/aes_cs_crc.sv
module aes_cs_crc
  import aes_enc_pkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CRC_LEN = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [$clog2(FRAMES)-1:0] frame_idx,
  input  logic                      c_in,
  output logic                      c_tx
);
  localparam int FW        = $clog2(FRAMES);
  localparam int CW        = $clog2(CRC_LEN);
  localparam int CRC_START = FRAMES - CRC_LEN;

  logic [7:0]    crc_q;
  logic          pro_q;
  logic [CW-1:0] crc_sel;
  logic          in_window;

  assign in_window = (frame_idx >= FW'(CRC_START));
  assign crc_sel   = CW'(frame_idx - FW'(CRC_START));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
      pro_q <= 1'b0;
      c_tx  <= 1'b0;
    end else if (load) begin
      if (frame_idx == '0) begin
        crc_q <= crc_step(CRC_PRESET, c_in);
        pro_q <= c_in;
        c_tx  <= c_in;
      end else if (!in_window) begin
        crc_q <= crc_step(crc_q, c_in);
        c_tx  <= c_in;
      end else begin
        c_tx  <= pro_q ? crc_q[crc_sel] : c_in;
      end
    end
  end

  p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(c_tx));

  p_crc_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_window) |=> $stable(crc_q));

endmodule

// File: rtl/aes_bmc_line.sv
module aes_bmc_line #(
  parameter int SLOTS     = 32,
  parameter int PRE_SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     live,
  input  logic                     half,
  input  logic [$clog2(SLOTS)-1:0] slot,
  input  logic [2*PRE_SLOTS-1:0]   pat,
  input  logic                     dbit,
  output logic                     tx
);
  localparam int SW  = $clog2(SLOTS);
  localparam int PW  = 2 * PRE_SLOTS;
  localparam int CIW = $clog2(PW);

  logic           in_pre;
  logic           pre_first;
  logic [CIW-1:0] cidx;
  logic           base_q;
  logic           seen_q;

  assign in_pre    = (slot < SW'(PRE_SLOTS));
  assign pre_first = (slot == '0) && !half;
  assign cidx      = CIW'({slot, half});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx     <= 1'b0;
      base_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (live) begin
      if (in_pre) begin
        if (pre_first) begin
          tx     <= pat[PW-1] ^ tx;
          base_q <= tx;
          seen_q <= 1'b1;
        end else begin
          tx <= pat[CIW'(PW - 1) - cidx] ^ base_q;
        end
      end else if (!half) begin
        tx <= ~tx;
      end else begin
        tx <= tx ^ dbit;
      end
    end
  end

  p_slot_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !in_pre && !half) |=> (tx != $past(tx)));

  // even parity plus the even transition count of each pattern bring the
  // line back to the level it had before the previous preamble
  p_level_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && seen_q && pre_first) |-> (tx == base_q));

endmodule

// File: rtl/aes_frame_encoder.sv
module aes_frame_encoder
  import aes_enc_pkg::*;
#(
  parameter int AUD_W   = 24,
  parameter int FRAMES  = 192,
  parameter int CRC_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mono_en,
  input  logic             mono_right,
  input  logic             cs_shared,
  input  logic             cs_right_sel,
  input  logic             mute,
  input  logic [AUD_W-1:0] aud_left,
  input  logic [AUD_W-1:0] aud_right,
  input  logic             vflag_a,
  input  logic             vflag_b,
  input  logic             ubit_a,
  input  logic             ubit_b,
  input  logic             cbit_a,
  input  logic             cbit_b,
  output logic             smp_req,
  output logic             tx
);
  localparam int SLOTS = PRE_SLOTS + AUD_W + TAIL_SLOTS;
  localparam int SW    = $clog2(SLOTS);
  localparam int FW    = $clog2(FRAMES);
  localparam int AW    = $clog2(AUD_W);
  localparam logic [SW-1:0] S_AUD = SW'(PRE_SLOTS);
  localparam logic [SW-1:0] S_V   = SW'(PRE_SLOTS + AUD_W);
  localparam logic [SW-1:0] S_U   = SW'(PRE_SLOTS + AUD_W + 1);
  localparam logic [SW-1:0] S_C   = SW'(PRE_SLOTS + AUD_W + 2);

  // timing
  logic          half, sub_b, sf_end;
  logic [SW-1:0] slot;
  logic [FW-1:0] frame, frame_nxt;

  aes_slot_timer #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .half      (half),
    .slot      (slot),
    .sub_b     (sub_b),
    .frame     (frame),
    .frame_nxt (frame_nxt),
    .sf_end    (sf_end)
  );

  logic req_a, req_b;
  assign req_a   = sf_end && sub_b;
  assign req_b   = sf_end && !sub_b && mono_en;
  assign smp_req = req_a || req_b;

  // capture registers
  logic             live_q;
  logic [AUD_W-1:0] aud_a_q, aud_b_q;
  logic             mute_a_q, mute_b_q;
  logic             v_a_q, v_b_q, u_a_q, u_b_q;
  logic [AUD_W-1:0] mono_pick;

  assign mono_pick = mono_right ? aud_right : aud_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      aud_a_q  <= '0;
      aud_b_q  <= '0;
      mute_a_q <= 1'b0;
      mute_b_q <= 1'b0;
      v_a_q    <= 1'b0;
      v_b_q    <= 1'b0;
      u_a_q    <= 1'b0;
      u_b_q    <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (req_a) begin
        aud_a_q  <= mono_en ? mono_pick : aud_left;
        mute_a_q <= mute;
        if (!mono_en) begin
          aud_b_q  <= aud_right;
          mute_b_q <= mute;
        end
        v_a_q <= vflag_a;
        v_b_q <= vflag_b;
        u_a_q <= ubit_a;
        u_b_q <= ubit_b;
      end else if (req_b) begin
        aud_b_q  <= mono_pick;
        mute_b_q <= mute;
      end
    end
  end

  // channel-status sourcing and CRC, one unit per subframe
  logic       cs_pick;
  logic [1:0] c_eff, c_tx;

  assign cs_pick = cs_right_sel ? cbit_b : cbit_a;

  for (genvar ch = 0; ch < 2; ch++) begin : g_cs
    assign c_eff[ch] = cs_shared ? cs_pick : ((ch == 0) ? cbit_a : cbit_b);

    aes_cs_crc #(.FRAMES(FRAMES), .CRC_LEN(CRC_LEN)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (req_a),
      .frame_idx (frame_nxt),
      .c_in      (c_eff[ch]),
      .c_tx      (c_tx[ch])
    );
  end

  // subframe assembly
  logic [AUD_W-1:0] aud_cur;
  logic             mute_cur, v_cur, u_cur, c_cur, p_cur;
  logic             aud_slot;
  logic [AW-1:0]    aidx;
  logic             dbit;
  pre_kind_e        pre_kind;
  logic [7:0]       pat;

  assign mute_cur = sub_b ? mute_b_q : mute_a_q;
  assign aud_cur  = mute_cur ? '0 : (sub_b ? aud_b_q : aud_a_q);
  assign v_cur    = sub_b ? v_b_q : v_a_q;
  assign u_cur    = sub_b ? u_b_q : u_a_q;
  assign c_cur    = sub_b ? c_tx[1] : c_tx[0];
  assign p_cur    = even_par(32'({c_cur, u_cur, v_cur, aud_cur}));
  assign aud_slot = (slot >= S_AUD) && (slot < S_V);
  assign aidx     = AW'(slot - S_AUD);

  always_comb begin
    if (aud_slot)         dbit = aud_cur[aidx];
    else if (slot == S_V) dbit = v_cur;
    else if (slot == S_U) dbit = u_cur;
    else if (slot == S_C) dbit = c_cur;
    else                  dbit = p_cur;
  end

  assign pre_kind = sub_b ? PRE_Y : ((frame == '0) ? PRE_Z : PRE_X);
  assign pat      = pre_cells(pre_kind);

  aes_bmc_line #(.SLOTS(SLOTS), .PRE_SLOTS(PRE_SLOTS)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (live_q),
    .half  (half),
    .slot  (slot),
    .pat   (pat),
    .dbit  (dbit),
    .tx    (tx)
  );

  p_mute_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && aud_slot && mute_cur) |-> !dbit);

  p_stereo_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mono_en && smp_req) |-> sub_b);

endmodule

// File: tb/aes_frame_encoder_tb_top.sv
module aes_frame_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mono_en = 1'b0, mono_right = 1'b0, cs_shared = 1'b0, cs_right_sel = 1'b0;
  logic        mute = 1'b0;
  logic [23:0] aud_left = '0, aud_right = '0;
  logic        vflag_a = 1'b0, vflag_b = 1'b0, ubit_a = 1'b0, ubit_b = 1'b0;
  logic        cbit_a = 1'b0, cbit_b = 1'b0;
  logic        smp_req, tx;

  always #4 clk = ~clk;

  aes_frame_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .mono_en(mono_en), .mono_right(mono_right),
    .cs_shared(cs_shared), .cs_right_sel(cs_right_sel), .mute(mute),
    .aud_left(aud_left), .aud_right(aud_right),
    .vflag_a(vflag_a), .vflag_b(vflag_b), .ubit_a(ubit_a), .ubit_b(ubit_b),
    .cbit_a(cbit_a), .cbit_b(cbit_b), .smp_req(smp_req), .tx(tx)
  );

  int checks = 0;
  int fails  = 0;
  int sample_no = 0;

  logic [31:0] exp_word [0:511];
  int          exp_pre  [0:511];
  string       exp_atag [0:511];
  string       exp_ctag [0:511];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [31:0] mk_word(logic [23:0] a, logic v, logic u, logic c);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 24; i++) w[4+i] = a[i];
    w[28] = v; w[29] = u; w[30] = c;
    w[31] = 1'b0;
    for (int i = 4; i < 31; i++) w[31] = w[31] ^ w[i];
    return w;
  endfunction

  function automatic logic [7:0] pre_pat(int k);
    if (k == 2) return 8'hE8;
    if (k == 1) return 8'hE4;
    return 8'hE2;
  endfunction

  function automatic logic [7:0] crc_model(logic [7:0] r, logic b);
    logic [7:0] m;
    m = {8{r[7] ^ b}} & 8'h1D;
    return (r << 1) ^ m;
  endfunction

  function automatic logic [23:0] next_audio();
    sample_no++;
    case (sample_no % 16)
      0: return 24'hFFFFFF;
      1: return 24'h000000;
      2: return 24'h800000;
      3: return 24'h000001;
      default: return 24'($urandom);
    endcase
  endfunction

  task automatic drive_new(int fnext, bit pro_a, bit pro_b, bit mono);
    aud_left  = next_audio();
    aud_right = next_audio();
    vflag_a = 1'($urandom); vflag_b = 1'($urandom);
    ubit_a  = 1'($urandom); ubit_b  = 1'($urandom);
    cbit_a  = 1'($urandom); cbit_b  = 1'($urandom);
    mute    = (($urandom % 8) == 0);
    if (mono) mono_right = 1'($urandom);
    if (fnext == 0) begin cbit_a = pro_a; cbit_b = pro_b; end
  endtask

  task automatic run_phase(bit mono, bit shared, bit rsel, int nframes, bit pro_a, bit pro_b);
    int total;
    total = nframes * 2;
    rst_n = 1'b0;
    mono_en = mono; cs_shared = shared; cs_right_sel = rsel; mono_right = 1'b0;
    drive_new(0, pro_a, pro_b, mono);
    repeat (2) begin
      @(negedge clk);
      chk(tx == 1'b0, "R1 tx during reset", int'(tx), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(smp_req == 1'b1, "R1 request right after release", int'(smp_req), 1);
    fork
      begin : stim
        int n = 0, f = 0, c = 0, last = -1;
        logic [7:0] crcm [2];
        bit   pro [2];
        logic pv = 1'b0, pu = 1'b0, pc = 1'b0;
        while (n < total) begin
          if (smp_req) begin
            if (last >= 0)
              chk((c - last) == (mono ? 64 : 128), "R2 request spacing", c - last, mono ? 64 : 128);
            last = c;
            if (!mono || (n % 2) == 0) begin
              logic ce [2];
              string ct [2];
              logic [23:0] aa;
              logic cpick;
              cpick = rsel ? cbit_b : cbit_a;
              ce[0] = shared ? cpick : cbit_a;
              ce[1] = shared ? cpick : cbit_b;
              for (int ch = 0; ch < 2; ch++) begin
                ct[ch] = "R9 V/U/C";
                if (f == 0) begin
                  pro[ch] = ce[ch];
                  crcm[ch] = crc_model(8'hFF, ce[ch]);
                end else if (f < 184) begin
                  crcm[ch] = crc_model(crcm[ch], ce[ch]);
                end else if (pro[ch]) begin
                  ce[ch] = crcm[ch][f - 184];
                  ct[ch] = "R10 CRC slot";
                end
              end
              aa = mono ? (mono_right ? aud_right : aud_left) : aud_left;
              if (mute) aa = '0;
              exp_word[n] = mk_word(aa, vflag_a, ubit_a, ce[0]);
              exp_pre[n]  = (f == 0) ? 2 : 0;
              exp_atag[n] = mute ? "R11 R3 muted audio" : (mono ? "R8 R3 mono audio" : "R7 R3 stereo audio");
              exp_ctag[n] = ct[0];
              if (!mono) begin
                exp_word[n+1] = mk_word(mute ? 24'h0 : aud_right, vflag_b, ubit_b, ce[1]);
                exp_pre[n+1]  = 1;
                exp_atag[n+1] = mute ? "R11 R3 muted audio" : "R7 R3 stereo audio";
                exp_ctag[n+1] = ct[1];
                n += 2;
                f = (f + 1) % 192;
              end else begin
                pv = vflag_b; pu = ubit_b; pc = ce[1];
                exp_ctag[n+1] = ct[1];
                n += 1;
              end
            end else begin
              logic [23:0] ab;
              ab = mono_right ? aud_right : aud_left;
              if (mute) ab = '0;
              exp_word[n] = mk_word(ab, pv, pu, pc);
              exp_pre[n]  = 1;
              exp_atag[n] = mute ? "R11 R3 muted audio" : "R8 R3 mono audio";
              n += 1;
              f = (f + 1) % 192;
            end
            @(posedge clk);
            #1;
            drive_new(f, pro_a, pro_b, mono);
            @(negedge clk);
            #1;
          end else begin
            @(negedge clk);
            #1;
          end
          c++;
        end
      end
      begin : mon
        logic lvl = 1'b0, base = 1'b0, prevtx = 1'b0;
        int bpre = 0, baud = 0, btail = 0, bpar = 0, bedge = 0;
        for (int c = 0; c < 2 + 64 * total; c++) begin
          if (c < 2) begin
            chk(tx == 1'b0, "R1 tx before first preamble", int'(tx), 0);
          end else begin
            int n, h, s;
            logic [7:0] pp;
            n = (c - 2) / 64;
            h = (c - 2) % 64;
            s = h / 2;
            if (h == 0) begin
              base = lvl; bpre = 0; baud = 0; btail = 0; bpar = 0; bedge = 0;
            end
            pp = pre_pat(exp_pre[n]);
            if (s < 4)           lvl = pp[7 - h] ^ base;
            else if (h % 2 == 0) lvl = ~lvl;
            else                 lvl = lvl ^ exp_word[n][s];
            if (tx !== lvl) begin
              if (s < 4)       bpre++;
              else if (s < 28) baud++;
              else if (s < 31) btail++;
              else             bpar++;
            end
            if (s >= 4 && (h % 2) == 0 && tx == prevtx) bedge++;
            if (h == 63) begin
              chk(bpre == 0, $sformatf("R5 preamble sf %0d kind %0d, wrong cells", n, exp_pre[n]), bpre, 0);
              chk(baud == 0, $sformatf("%s sf %0d word %h, wrong cells", exp_atag[n], n, exp_word[n]), baud, 0);
              chk(btail == 0, $sformatf("%s sf %0d word %h, wrong cells", exp_ctag[n], n, exp_word[n]), btail, 0);
              chk(bpar == 0, $sformatf("R4 parity sf %0d word %h, wrong cells", n, exp_word[n]), bpar, 0);
              chk(bedge == 0, $sformatf("R6 slot-start edges sf %0d, missing", n), bedge, 0);
            end
          end
          prevtx = tx;
          @(negedge clk);
          #1;
        end
      end
    join
  endtask

  initial begin
    void'($urandom(32'h0005EED1));
    // stereo, separate sources, professional block on A only
    run_phase(1'b0, 1'b0, 1'b0, 196, 1'b1, 1'b0);
    // stereo, both subframes from the A input, which is consumer
    run_phase(1'b0, 1'b1, 1'b0, 196, 1'b0, 1'b1);
    // mono, both subframes from the B input, which is professional
    run_phase(1'b1, 1'b1, 1'b1, 196, 1'b0, 1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule